// File: doc/BRIEF.md
# PWM Output Mode Steering Stage

This block sits between a duty-cycle generator and the two pins of a half-bridge, a high pin and a low pin. It takes the raw duty signal for each side and turns it into the two pin values and their output enables. It supports three operating modes. Complementary mode drives the low side as the inverse of the high side and adds a programmable dead time. Independent mode lets each side follow its own duty input. Push-pull mode sends the high-side duty pulse to the two pins in turn, one cycle-start pulse after another.

After the mode logic, the output path applies the following stages in this fixed order: per-pin override, high/low swap, per-pin polarity, and finally a pin-ownership gate. Configuration is loaded through a single write strobe. While a lock input is high, the mode, polarity and ownership fields ignore writes. The swap bit, the force-on choice and the dead-time count are loaded even while the lock is high. A force-on choice controls how an override acts in complementary mode. It can either replace the pin values at once, or steer the complementary pair through the dead-time insertion.

Top module: `pwm_out_steer`

## Requirements
- R1: The 2-bit mode field selects the operation: 0 is complementary, 1 is independent, 2 is push-pull. Value 3 behaves exactly as complementary.
- R2: In complementary mode the low side is the inverse of the high side. When the pair target changes, both sides are low for exactly `dead` clock cycles. After that, the new level appears. With `dead` = 0 the outputs follow the target one cycle after the change.
- R3: In independent mode the high and low sides follow `duty_h` and `duty_l`, each delayed by one clock cycle, with no dead time.
- R4: In push-pull mode a steering bit is cleared by reset and toggles on every clock where `cycle_start` is 1. The high side carries `duty_h` while the bit is 0, and the low side carries `duty_h` while the bit is 1. The other side is 0.
- R5: Per-pin override requests (`ovr_en_*`/`ovr_val_*`) replace the mode-logic value of that side in the same cycle. This applies in independent and push-pull modes, and in complementary mode when force-on is 1.
- R6: In complementary mode with force-on 0, an active high-side override becomes the complementary pair target and takes effect only after the dead time. The low-side override has no effect in that case.
- R7: With swap 1, the high-side signal drives `pin_l` and the low-side signal drives `pin_h`. With swap 0, each side drives its own pin.
- R8: The polarity bit of a pin inverts that pin's value after the swap.
- R9: `oe_h`/`oe_l` equal the pin's ownership bit. A pin whose ownership bit is 0 is driven 0.
- R10: A configuration write with `cfg_lock` 1 leaves mode, polarity and ownership unchanged. Swap, force-on and the dead-time count are still loaded.
- R11: After reset the mode is complementary, both ownership, polarity and swap bits are 0, and `pin_h`, `pin_l`, `oe_h`, `oe_l` are all 0.
- R12: A configuration write takes effect on the clock edge where `cfg_wr` is sampled high. The outputs before that edge still reflect the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | One-cycle pulse at the start of each PWM period |
| duty_h | input | 1 | Raw high-side duty signal |
| duty_l | input | 1 | Raw low-side duty signal (independent mode) |
| ovr_en_h | input | 1 | High-side override request |
| ovr_val_h | input | 1 | High-side override value |
| ovr_en_l | input | 1 | Low-side override request |
| ovr_val_l | input | 1 | Low-side override value |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_lock | input | 1 | Protects mode, polarity and ownership from writes |
| cfg_mode | input | 2 | Mode: 0 complementary, 1 independent, 2 push-pull, 3 as 0 |
| cfg_swap | input | 1 | Exchange high and low pin assignment |
| cfg_force_on | input | 1 | Override bypasses dead time in complementary mode |
| cfg_pol_h | input | 1 | Invert high pin |
| cfg_pol_l | input | 1 | Invert low pin |
| cfg_pen_h | input | 1 | Block owns the high pin |
| cfg_pen_l | input | 1 | Block owns the low pin |
| cfg_dead | input | DT_W | Dead-time length in clock cycles |
| pin_h | output | 1 | High pin value |
| pin_l | output | 1 | Low pin value |
| oe_h | output | 1 | High pin output enable |
| oe_l | output | 1 | Low pin output enable |

## Verification
The hardest situation to reach is an override that enters through the dead-time path. This needs complementary mode, force-on 0, a settled pair, and then a high-side override whose value differs from the current target. The bench configures exactly that state and lets it settle. It then raises the override between clock edges. It first samples before the next edge to show that nothing changed immediately, then counts the dead cycles one by one. A second case holds a low-side override in that same state to show that it has no effect. For the lock rule, the bench writes a mode value whose effect would be visible in the outputs, so that a write that slipped through the lock shows up at the pins.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  typedef enum logic [1:0] {
    MODE_COMP  = 2'd0,
    MODE_INDEP = 2'd1,
    MODE_PP    = 2'd2,
    MODE_RSVD  = 2'd3
  } pwm_mode_e;

  // pin index: 1 = high side, 0 = low side
  typedef struct packed {
    pwm_mode_e  mode;
    logic       swap;
    logic       force_on;
    logic [1:0] pol;
    logic [1:0] pen;
  } steer_cfg_t;

  function automatic logic is_comp(input pwm_mode_e m);
    return (m == MODE_COMP) || (m == MODE_RSVD);
  endfunction

endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
  import pwm_steer_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            lock,
  input  steer_cfg_t      wr_cfg,
  input  logic [DT_W-1:0] wr_dead,
  output steer_cfg_t      cfg_q,
  output logic [DT_W-1:0] dead_q
);

  steer_cfg_t      cfg_d;
  logic [DT_W-1:0] dead_d;

  always_comb begin
    cfg_d  = cfg_q;
    dead_d = dead_q;
    if (wr) begin
      cfg_d.swap     = wr_cfg.swap;
      cfg_d.force_on = wr_cfg.force_on;
      dead_d         = wr_dead;
      if (!lock) begin
        cfg_d.mode = wr_cfg.mode;
        cfg_d.pol  = wr_cfg.pol;
        cfg_d.pen  = wr_cfg.pen;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{mode: MODE_COMP, swap: 1'b0, force_on: 1'b0, pol: 2'b00, pen: 2'b00};
      dead_q <= '0;
    end else if (wr) begin
      cfg_q  <= cfg_d;
      dead_q <= dead_d;
    end
  end

endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            target,
  input  logic [DT_W-1:0] dead,
  output logic            out_h,
  output logic            out_l,
  output logic            busy
);

  logic            tgt_q, tgt_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            upd;

  assign upd = (target != tgt_q) || (cnt_q != '0);

  always_comb begin
    tgt_d = tgt_q;
    cnt_d = cnt_q;
    if (target != tgt_q) begin
      tgt_d = target;
      cnt_d = dead;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy  = (cnt_q != '0);
  assign out_h = tgt_q & ~busy;
  assign out_l = ~tgt_q & ~busy;

endmodule

// File: rtl/pwm_mode_stage.sv
module pwm_mode_stage
  import pwm_steer_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pwm_mode_e       mode,
  input  logic            duty_h,
  input  logic            duty_l,
  input  logic            comp_tgt,
  input  logic            cycle_start,
  input  logic [DT_W-1:0] dead,
  output logic            out_h,
  output logic            out_l,
  output logic            cmp_h,
  output logic            cmp_l,
  output logic            dt_busy,
  output logic            steer
);

  logic steer_q, steer_d;
  logic mh_q, ml_q, mh_d, ml_d;

  pwm_deadtime #(.DT_W(DT_W)) u_dead (
    .clk    (clk),
    .rst_n  (rst_n),
    .target (comp_tgt),
    .dead   (dead),
    .out_h  (cmp_h),
    .out_l  (cmp_l),
    .busy   (dt_busy)
  );

  always_comb begin
    steer_d = steer_q ^ cycle_start;
    mh_d    = 1'b0;
    ml_d    = 1'b0;
    case (mode)
      MODE_INDEP: begin
        mh_d = duty_h;
        ml_d = duty_l;
      end
      MODE_PP: begin
        mh_d = duty_h & ~steer_q;
        ml_d = duty_h & steer_q;
      end
      default: begin
        mh_d = 1'b0;
        ml_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steer_q <= 1'b0;
      mh_q    <= 1'b0;
      ml_q    <= 1'b0;
    end else begin
      steer_q <= steer_d;
      mh_q    <= mh_d;
      ml_q    <= ml_d;
    end
  end

  assign out_h = is_comp(mode) ? cmp_h : mh_q;
  assign out_l = is_comp(mode) ? cmp_l : ml_q;
  assign steer = steer_q;

endmodule

// File: rtl/pwm_out_steer.sv
module pwm_out_steer
  import pwm_steer_pkg::*;
#(
  parameter int DT_W       = 4,
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cycle_start,
  input  logic            duty_h,
  input  logic            duty_l,
  input  logic            ovr_en_h,
  input  logic            ovr_val_h,
  input  logic            ovr_en_l,
  input  logic            ovr_val_l,
  input  logic            cfg_wr,
  input  logic            cfg_lock,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_swap,
  input  logic            cfg_force_on,
  input  logic            cfg_pol_h,
  input  logic            cfg_pol_l,
  input  logic            cfg_pen_h,
  input  logic            cfg_pen_l,
  input  logic [DT_W-1:0] cfg_dead,
  output logic            pin_h,
  output logic            pin_l,
  output logic            oe_h,
  output logic            oe_l
);

  localparam int NPIN = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  steer_cfg_t      wr_cfg, cfg_q;
  logic [DT_W-1:0] dead_q;

  assign wr_cfg = '{mode:     pwm_mode_e'(cfg_mode),
                    swap:     cfg_swap,
                    force_on: cfg_force_on,
                    pol:      {cfg_pol_h, cfg_pol_l},
                    pen:      {cfg_pen_h, cfg_pen_l}};

  pwm_cfg_reg #(.DT_W(DT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr      (cfg_wr),
    .lock    (cfg_lock),
    .wr_cfg  (wr_cfg),
    .wr_dead (cfg_dead),
    .cfg_q   (cfg_q),
    .dead_q  (dead_q)
  );

  // override routed through dead time when force-on is clear
  logic comp_mode, late_ovr, comp_tgt;
  assign comp_mode = is_comp(cfg_q.mode);
  assign late_ovr  = comp_mode & ~cfg_q.force_on;
  assign comp_tgt  = (late_ovr & ovr_en_h) ? ovr_val_h : duty_h;

  logic mode_h, mode_l, cmp_h, cmp_l, dt_busy, steer;

  pwm_mode_stage #(.DT_W(DT_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .mode        (cfg_q.mode),
    .duty_h      (duty_h),
    .duty_l      (duty_l),
    .comp_tgt    (comp_tgt),
    .cycle_start (cycle_start),
    .dead        (dead_q),
    .out_h       (mode_h),
    .out_l       (mode_l),
    .cmp_h       (cmp_h),
    .cmp_l       (cmp_l),
    .dt_busy     (dt_busy),
    .steer       (steer)
  );

  // output path: override -> swap -> polarity -> ownership gate
  logic [NPIN-1:0] mode_v, ovr_en_v, ovr_val_v, ovr_o, swp_o, pin_v;
  assign mode_v    = {mode_h, mode_l};
  assign ovr_en_v  = {ovr_en_h, ovr_en_l};
  assign ovr_val_v = {ovr_val_h, ovr_val_l};

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_pin
      always_comb begin
        ovr_o[gi] = (!late_ovr && ovr_en_v[gi]) ? ovr_val_v[gi] : mode_v[gi];
      end
      assign swp_o[gi] = cfg_q.swap ? ovr_o[NPIN-1-gi] : ovr_o[gi];
      assign pin_v[gi] = cfg_q.pen[gi] & (swp_o[gi] ^ cfg_q.pol[gi]);
    end
  endgenerate

  assign pin_h = pin_v[1];
  assign pin_l = pin_v[0];
  assign oe_h  = cfg_q.pen[1];
  assign oe_l  = cfg_q.pen[0];

endmodule

// File: rtl/pwm_out_steer_chk.sv
module pwm_out_steer_chk
  import pwm_steer_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cycle_start,
  input logic       cfg_wr,
  input logic       cfg_lock,
  input pwm_mode_e  mode_q,
  input logic [1:0] pen_q,
  input logic [1:0] pol_q,
  input logic       steer,
  input logic       dt_busy,
  input logic       cmp_h,
  input logic       cmp_l,
  input logic       mode_h,
  input logic       duty_h,
  input logic       pin_h,
  input logic       pin_l,
  input logic       oe_h,
  input logic       oe_l
);

  AST_COMP_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_h && cmp_l)); // R2

  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dt_busy |-> (!cmp_h && !cmp_l)); // R2

  AST_INDEP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_INDEP && $past(mode_q) == MODE_INDEP) |-> (mode_h == $past(duty_h))); // R3

  AST_STEER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> (steer != $past(steer))); // R4

  AST_STEER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(steer)); // R4

  AST_UNOWNED_H_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_h |-> !pin_h); // R9

  AST_UNOWNED_L_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_l |-> !pin_l); // R9

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_lock) |=> ($stable(mode_q) && $stable(pen_q) && $stable(pol_q))); // R10

endmodule

bind pwm_out_steer pwm_out_steer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .cycle_start (cycle_start),
  .cfg_wr      (cfg_wr),
  .cfg_lock    (cfg_lock),
  .mode_q      (cfg_q.mode),
  .pen_q       (cfg_q.pen),
  .pol_q       (cfg_q.pol),
  .steer       (steer),
  .dt_busy     (dt_busy),
  .cmp_h       (cmp_h),
  .cmp_l       (cmp_l),
  .mode_h      (mode_h),
  .duty_h      (duty_h),
  .pin_h       (pin_h),
  .pin_l       (pin_l),
  .oe_h        (oe_h),
  .oe_l        (oe_l)
);

// File: tb/pwm_out_steer_bench.sv
`timescale 1ns/1ps
module pwm_out_steer_bench;

  localparam int DT_W  = 4;
  localparam int NVEC  = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cycle_start, duty_h, duty_l;
  logic ovr_en_h, ovr_val_h, ovr_en_l, ovr_val_l;
  logic cfg_wr, cfg_lock, cfg_swap, cfg_force_on;
  logic cfg_pol_h, cfg_pol_l, cfg_pen_h, cfg_pen_l;
  logic [1:0] cfg_mode;
  logic [DT_W-1:0] cfg_dead;
  logic pin_h, pin_l, oe_h, oe_l;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwm_out_steer #(.DT_W(DT_W)) u_pwm_out_steer (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .duty_h(duty_h), .duty_l(duty_l),
    .ovr_en_h(ovr_en_h), .ovr_val_h(ovr_val_h),
    .ovr_en_l(ovr_en_l), .ovr_val_l(ovr_val_l),
    .cfg_wr(cfg_wr), .cfg_lock(cfg_lock), .cfg_mode(cfg_mode),
    .cfg_swap(cfg_swap), .cfg_force_on(cfg_force_on),
    .cfg_pol_h(cfg_pol_h), .cfg_pol_l(cfg_pol_l),
    .cfg_pen_h(cfg_pen_h), .cfg_pen_l(cfg_pen_l),
    .cfg_dead(cfg_dead),
    .pin_h(pin_h), .pin_l(pin_l), .oe_h(oe_h), .oe_l(oe_l)
  );

  // {mode[1:0], swap, pol_h, pol_l, pen_h, pen_l, ovr_en_h, ovr_val_h,
  //  ovr_en_l, ovr_val_l, force_on, duty_h, duty_l, exp_pin_h, exp_pin_l}
  localparam logic [15:0] VEC [NVEC] = '{
    16'b00_0_0_0_1_1_0_0_0_0_0_1_0_1_0, // R1 R2 complementary, duty high
    16'b00_0_0_0_1_1_0_0_0_0_0_0_0_0_1, // R2 complementary, duty low
    16'b01_0_0_0_1_1_0_0_0_0_0_1_1_1_1, // R3 independent both high
    16'b01_0_0_0_1_1_0_0_0_0_0_0_1_0_1, // R3 independent low only
    16'b01_1_0_0_1_1_0_0_0_0_0_1_0_0_1, // R7 swap
    16'b01_0_1_0_1_1_0_0_0_0_0_1_0_0_0, // R8 high polarity
    16'b01_1_0_1_1_1_0_0_0_0_0_1_0_0_0, // R7 R8 swap then low polarity
    16'b01_0_0_0_0_1_0_0_0_0_0_1_1_0_1, // R9 high pin not owned
    16'b01_0_0_0_1_1_1_0_0_0_0_1_1_0_1, // R5 high override to 0
    16'b00_0_0_0_1_1_0_0_1_1_1_1_0_1_1, // R5 force-on low override in comp
    16'b11_0_0_0_1_1_0_0_0_0_0_1_1_1_0, // R1 reserved acts as complementary
    16'b01_1_0_0_1_1_0_0_1_1_0_0_0_1_0  // R5 R7 override before swap
  };

  task automatic check2(input string tag, input logic [1:0] act, input logic [1:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic sw, input logic ph, input logic pl,
                           input logic eh, input logic el, input logic fon,
                           input logic [DT_W-1:0] dt, input logic lk);
    cfg_mode = m; cfg_swap = sw; cfg_pol_h = ph; cfg_pol_l = pl;
    cfg_pen_h = eh; cfg_pen_l = el; cfg_force_on = fon; cfg_dead = dt;
    cfg_lock = lk; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_lock = 1'b0;
  endtask

  task automatic clear_ovr();
    ovr_en_h = 1'b0; ovr_val_h = 1'b0; ovr_en_l = 1'b0; ovr_val_l = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cycle_start = 1'b0; duty_h = 1'b0; duty_l = 1'b0;
    ovr_en_h = 1'b0; ovr_val_h = 1'b0; ovr_en_l = 1'b0; ovr_val_l = 1'b0;
    cfg_wr = 1'b0; cfg_lock = 1'b0; cfg_mode = 2'd0; cfg_swap = 1'b0;
    cfg_force_on = 1'b0; cfg_pol_h = 1'b0; cfg_pol_l = 1'b0;
    cfg_pen_h = 1'b0; cfg_pen_l = 1'b0; cfg_dead = '0;

    // R11 reset state
    repeat (3) @(negedge clk);
    check2("R11 pins in reset", {pin_h, pin_l}, 2'b00);
    check2("R11 oe in reset", {oe_h, oe_l}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check2("R11 pins after reset", {pin_h, pin_l}, 2'b00);
    check2("R11 oe after reset", {oe_h, oe_l}, 2'b00);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      ovr_en_h = v[8]; ovr_val_h = v[7]; ovr_en_l = v[6]; ovr_val_l = v[5];
      duty_h = v[3]; duty_l = v[2];
      write_cfg(v[15:14], v[13], v[12], v[11], v[10], v[9], v[4], 4'd2, 1'b0);
      repeat (6) @(negedge clk);
      check2($sformatf("vector %0d pins", i), {pin_h, pin_l}, v[1:0]);
      check2($sformatf("vector %0d oe R9", i), {oe_h, oe_l}, v[10:9]);
    end
    clear_ovr();

    // R2 dead time on a rising and a falling target, dead = 3
    duty_h = 1'b0;
    write_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 1'b0);
    repeat (6) @(negedge clk);
    check2("R2 settled low", {pin_h, pin_l}, 2'b01);
    duty_h = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check2($sformatf("R2 dead cycle %0d rising", k), {pin_h, pin_l}, 2'b00);
    end
    @(negedge clk);
    check2("R2 high after dead", {pin_h, pin_l}, 2'b10);
    duty_h = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check2($sformatf("R2 dead cycle %0d falling", k), {pin_h, pin_l}, 2'b00);
    end
    @(negedge clk);
    check2("R2 low after dead", {pin_h, pin_l}, 2'b01);

    // R2 zero dead time
    write_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
    duty_h = 1'b1;
    @(negedge clk);
    check2("R2 zero dead follows in one cycle", {pin_h, pin_l}, 2'b10);

    // R6 override through dead time, force-on clear
    duty_h = 1'b0;
    write_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 1'b0);
    repeat (6) @(negedge clk);
    ovr_en_h = 1'b1; ovr_val_h = 1'b1;
    #1 check2("R6 no immediate override", {pin_h, pin_l}, 2'b01);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check2($sformatf("R6 dead cycle %0d", k), {pin_h, pin_l}, 2'b00);
    end
    @(negedge clk);
    check2("R6 override after dead", {pin_h, pin_l}, 2'b10);
    clear_ovr();
    duty_h = 1'b1;
    repeat (6) @(negedge clk);
    ovr_en_l = 1'b1; ovr_val_l = 1'b1;
    repeat (5) @(negedge clk);
    check2("R6 low override has no effect", {pin_h, pin_l}, 2'b10);
    clear_ovr();

    // R5 force-on: immediate override in complementary mode
    duty_h = 1'b0;
    write_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 1'b0);
    repeat (6) @(negedge clk);
    ovr_en_h = 1'b1; ovr_val_h = 1'b1;
    #1 check2("R5 force-on immediate", {pin_h, pin_l}, 2'b11);
    @(negedge clk);
    clear_ovr();

    // R3 one-cycle latency in independent mode
    duty_h = 1'b0; duty_l = 1'b0;
    write_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 1'b0);
    repeat (3) @(negedge clk);
    duty_h = 1'b1;
    #1 check2("R3 not yet", {pin_h, pin_l}, 2'b00);
    @(negedge clk);
    check2("R3 after one cycle, no dead time", {pin_h, pin_l}, 2'b10);

    // R4 push-pull alternation
    duty_h = 1'b1;
    write_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
    repeat (3) @(negedge clk);
    check2("R4 first period on high", {pin_h, pin_l}, 2'b10);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    @(negedge clk);
    check2("R4 second period on low", {pin_h, pin_l}, 2'b01);
    repeat (3) @(negedge clk);
    check2("R4 holds without cycle start", {pin_h, pin_l}, 2'b01);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
    @(negedge clk);
    check2("R4 back to high", {pin_h, pin_l}, 2'b10);
    duty_h = 1'b0;
    repeat (2) @(negedge clk);
    check2("R4 no duty no drive", {pin_h, pin_l}, 2'b00);

    // R12 write timing
    duty_h = 1'b1; duty_l = 1'b0;
    write_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
    repeat (3) @(negedge clk);
    cfg_pol_h = 1'b1; cfg_wr = 1'b1;
    #1 check2("R12 old setting before edge", {pin_h, pin_l}, 2'b10);
    @(negedge clk);
    cfg_wr = 1'b0;
    check2("R12 new setting after edge", {pin_h, pin_l}, 2'b00);

    // R10 lock
    duty_h = 1'b1; duty_l = 1'b1;
    write_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
    repeat (3) @(negedge clk);
    write_cfg(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1);
    repeat (3) @(negedge clk);
    check2("R10 locked fields held", {pin_h, pin_l}, 2'b11);
    check2("R10 ownership held", {oe_h, oe_l}, 2'b11);
    duty_l = 1'b0;
    repeat (2) @(negedge clk);
    check2("R10 swap loaded under lock", {pin_h, pin_l}, 2'b01);
    write_cfg(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0);
    @(negedge clk);
    check2("R10 unlocked write applies", {pin_h, pin_l}, 2'b01);
    check2("R10 R9 unlocked ownership", {oe_h, oe_l}, 2'b01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule